// File: doc/BRIEF.md
# Debug-Gated AHB-Lite Single-Transfer Master

This block sits between a debug-side register interface and an AHB-Lite system bus. A requester presents one access at a time. The access carries an address, a size, write data, five software protection bits, a non-secure select and a packed flag. The block decides whether the access may reach the bus at all. It is refused when debug is disabled, when a Secure access lacks permission, or when the size or alignment is not legal. A refused access gets an error response and never touches the bus. An accepted access is driven as isolated NONSEQ SINGLE transfers. The block forms the protection bits and the byte-lane strobes itself.

When the packed flag is set with a byte or half-word size, the request word is split into one transfer per lane. The split starts at the addressed lane and runs up to the top lane of the word, with the address stepping by the transfer size. Read bytes are gathered into their own lanes of the returned word. The first bus error ends the sequence. Every accepted request receives exactly one response pulse, which carries the error flag and the assembled read data.

Top module: `dbgAhbSingleMaster`

## Requirements
- R1: A request is taken only on a clock edge where `reqReady` and `reqValid` are both high. `reqValid` is ignored while `reqReady` is low. Each taken request yields exactly one `rspValid` pulse, one cycle long.
- R2: With `dbgEnable` low when a request is taken, no bus transfer starts. `rspValid` and `rspErr` are high in the next cycle.
- R3: A request with `reqNonSec`=0 (Secure) taken while `secureAllow` is low starts no bus transfer and answers with an error. With `secureAllow` high, it is issued with `hprot[6]`=0.
- R4: During a transfer, `hprot[6]` equals the request's `reqNonSec` and `hprot[5]` and `hprot[2]` are 0. `hprot[4:3]` and `hprot[1:0]` equal the same bits of `reqProt`.
- R5: `hbstrb` has bit i set for each byte lane i that the transfer covers, from lane `haddr[1:0]` for 2^`hsize` lanes. For example, a byte at offset 3 gives 4'b1000, a half-word at offset 2 gives 4'b1100, and a word gives 4'b1111.
- R6: A request with `reqSize` above 2 (2 = word, 1 = half-word, 0 = byte), or with an address not aligned to its size, starts no bus transfer and answers with an error.
- R7: `htrans` is 2'b10 (NONSEQ) only in address phases and 2'b00 (IDLE) otherwise. Each address phase that meets `hready` high is followed by an IDLE cycle. `hburst` is always 3'b000 (SINGLE).
- R8: While `hready` is low, the address phase holds `htrans` and `haddr` unchanged. The data phase ends on the first cycle with `hready` high, and the response pulse follows in the next cycle.
- R9: Any `hresp` other than 2'b00 at data-phase completion makes the response carry `rspErr`=1.
- R10: With `reqPacked`=1 and size 0 or 1, the block issues (4 − offset)/2^size transfers at incrementing addresses. `rspData` holds each read byte in its own lane and zero elsewhere. A packed word is a single transfer.
- R11: In a packed sequence, the first transfer that receives an error ends the sequence. No further transfer is issued, and the response carries `rspErr`=1.
- R12: During and right after reset, `htrans` is IDLE, `reqReady` is high and `rspValid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request strobe |
| reqReady | output | 1 | Block is idle and can take a request |
| reqAddr | input | 32 | Byte address |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqSize | input | 3 | log2 of bytes per transfer |
| reqWdata | input | 32 | Write word, bytes in their address lanes |
| reqProt | input | 5 | Software protection bits |
| reqNonSec | input | 1 | 1 = Non-secure, 0 = Secure |
| reqPacked | input | 1 | Split the word into sub-word transfers |
| rspValid | output | 1 | One-cycle response pulse |
| rspErr | output | 1 | Response is an error |
| rspData | output | 32 | Assembled read data |
| dbgEnable | input | 1 | Debug access enable |
| secureAllow | input | 1 | Secure accesses permitted |
| haddr | output | 32 | Bus address |
| htrans | output | 2 | Transfer type |
| hwrite | output | 1 | Bus write |
| hsize | output | 3 | Bus size |
| hburst | output | 3 | Burst type, always SINGLE |
| hprot | output | 7 | Protection and security bits |
| hbstrb | output | 4 | Byte-lane strobes |
| hwdata | output | 32 | Bus write data |
| hrdata | input | 32 | Bus read data |
| hready | input | 1 | Bus ready |
| hresp | input | 2 | Bus response |

## Verification
A refused request answers on the cycle right after the edge that takes it, so the bench samples `rspValid` at the first falling edge after acceptance. A request that reaches the bus answers one cycle after the data phase meets `hready` high. The bench's slave model can insert wait states and hold `hready` low, so the bench waits for the pulse at falling edges instead of assuming a fixed count. The bus side is recorded by the slave model at the rising edge that completes each address phase, and the bench reads those records only after the response. The pulse width is checked one falling edge after the pulse, and the absence of stray responses over several following cycles.

// File: rtl/dbgAhbPkg.sv
package dbgAhbPkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_ADDR,
    ST_DATA
  } ctlState_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic load;       // take a new request
    logic addrPhase;  // bus address phase active
    logic capture;    // data phase completes this cycle
    logic advance;    // step to next packed lane
  } ctlStrobe_t;

  localparam logic [1:0] HTRANS_IDLE   = 2'b00;
  localparam logic [1:0] HTRANS_NONSEQ = 2'b10;
  localparam logic [2:0] HBURST_SINGLE = 3'b000;

endpackage

// File: rtl/dbgAhbDatapath.sv
module dbgAhbDatapath
  import dbgAhbPkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctlStrobe_t        strobe,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic              reqWrite,
  input  logic [2:0]        reqSize,
  input  logic [DATA_W-1:0] reqWdata,
  input  logic [4:0]        reqProt,
  input  logic              reqNonSec,
  input  logic              reqPacked,
  input  logic              dbgEnable,
  input  logic              secureAllow,
  input  logic [DATA_W-1:0] hrdata,
  output logic              reqFault,
  output logic              lastBeat,
  output logic [ADDR_W-1:0] haddr,
  output logic              hwrite,
  output logic [2:0]        hsize,
  output logic [6:0]        hprot,
  output logic [DATA_W/8-1:0] hbstrb,
  output logic [DATA_W-1:0] hwdata,
  output logic [DATA_W-1:0] rspData
);

  localparam int LANES = DATA_W / 8;
  localparam int OFF_W = $clog2(LANES);
  localparam int CNT_W = OFF_W + 1;
  localparam logic [2:0] SIZE_MAX = 3'(OFF_W);

  function automatic logic [LANES-1:0] laneMask(input logic [2:0] sz,
                                                input logic [OFF_W-1:0] off);
    int unsigned lo;
    int unsigned hi;
    lo = 32'(off);
    hi = lo + (32'd1 << sz);
    for (int unsigned i = 0; i < LANES; i++) begin
      laneMask[i] = (i >= lo) && (i < hi);
    end
  endfunction

  logic [ADDR_W-1:0] addrR;
  logic [2:0]        sizeR;
  logic              writeR;
  logic [DATA_W-1:0] wdataR;
  logic [4:0]        protR;
  logic              nonSecR;
  logic [CNT_W-1:0]  beatsR;
  logic [DATA_W-1:0] accR;

  // Request screening and beat count
  int unsigned       offInt;
  int unsigned       sizeInt;
  logic              sizeBad;
  logic              misaligned;
  logic [CNT_W-1:0]  reqBeats;

  always_comb begin
    offInt     = 32'(reqAddr[OFF_W-1:0]);
    sizeInt    = 32'(reqSize);
    sizeBad    = reqSize > SIZE_MAX;
    misaligned = !sizeBad && ((offInt & ((32'd1 << sizeInt) - 32'd1)) != 0);
    reqFault   = !dbgEnable || (!reqNonSec && !secureAllow) || sizeBad || misaligned;
    if (reqPacked && (reqSize < SIZE_MAX)) begin
      reqBeats = CNT_W'((32'(LANES) - offInt) >> sizeInt);
    end else begin
      reqBeats = CNT_W'(1);
    end
  end

  // Byte strobes expanded to a bit mask for read gathering
  logic [LANES-1:0]  strbNow;
  logic [DATA_W-1:0] bitMask;

  assign strbNow = laneMask(sizeR, addrR[OFF_W-1:0]);

  for (genvar g = 0; g < LANES; g++) begin : gLaneMask
    assign bitMask[8*g +: 8] = {8{strbNow[g]}};
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      addrR   <= '0;
      sizeR   <= '0;
      writeR  <= 1'b0;
      wdataR  <= '0;
      protR   <= '0;
      nonSecR <= 1'b1;
      beatsR  <= '0;
      accR    <= '0;
    end else if (strobe.load) begin
      addrR   <= reqAddr;
      sizeR   <= reqSize;
      writeR  <= reqWrite;
      wdataR  <= reqWdata;
      protR   <= reqProt;
      nonSecR <= reqNonSec;
      beatsR  <= reqBeats;
      accR    <= '0;
    end else begin
      if (strobe.capture && !writeR) begin
        accR <= accR | (hrdata & bitMask);
      end
      if (strobe.advance) begin
        addrR  <= addrR + (ADDR_W'(1) << sizeR);
        beatsR <= beatsR - CNT_W'(1);
      end
    end
  end

  assign lastBeat = beatsR == CNT_W'(1);
  assign haddr    = addrR;
  assign hwrite   = writeR;
  assign hsize    = sizeR;
  assign hwdata   = wdataR;
  assign hbstrb   = strbNow;
  assign hprot    = {nonSecR, 1'b0, protR[4:3], 1'b0, protR[1:0]};
  assign rspData  = accR;

endmodule

// File: rtl/dbgAhbControl.sv
module dbgAhbControl
  import dbgAhbPkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       reqValid,
  input  logic       reqFault,
  input  logic       lastBeat,
  input  logic       hready,
  input  logic [1:0] hresp,
  output ctlStrobe_t strobe,
  output logic       reqReady,
  output logic       rspValid,
  output logic       rspErr
);

  ctlState_e state;
  ctlState_e stateNext;
  logic      busErr;
  logic      finish;

  assign busErr = hresp != 2'b00;

  always_comb begin
    strobe    = '0;
    stateNext = state;
    finish    = 1'b0;
    unique case (state)
      ST_IDLE: begin
        if (reqValid) begin
          strobe.load = 1'b1;
          if (!reqFault) stateNext = ST_ADDR;
        end
      end
      ST_ADDR: begin
        strobe.addrPhase = 1'b1;
        if (hready) stateNext = ST_DATA;
      end
      ST_DATA: begin
        if (hready) begin
          strobe.capture = 1'b1;
          if (busErr || lastBeat) begin
            finish    = 1'b1;
            stateNext = ST_IDLE;
          end else begin
            strobe.advance = 1'b1;
            stateNext      = ST_ADDR;
          end
        end
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      rspValid <= 1'b0;
      rspErr   <= 1'b0;
    end else begin
      state    <= stateNext;
      rspValid <= 1'b0;
      if (state == ST_IDLE && reqValid && reqFault) begin
        rspValid <= 1'b1;
        rspErr   <= 1'b1;
      end else if (finish) begin
        rspValid <= 1'b1;
        rspErr   <= busErr;
      end
    end
  end

  assign reqReady = state == ST_IDLE;

endmodule

// File: rtl/dbgAhbSingleMaster.sv
module dbgAhbSingleMaster
  import dbgAhbPkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic              reqWrite,
  input  logic [2:0]        reqSize,
  input  logic [DATA_W-1:0] reqWdata,
  input  logic [4:0]        reqProt,
  input  logic              reqNonSec,
  input  logic              reqPacked,
  output logic              rspValid,
  output logic              rspErr,
  output logic [DATA_W-1:0] rspData,
  input  logic              dbgEnable,
  input  logic              secureAllow,
  output logic [ADDR_W-1:0] haddr,
  output logic [1:0]        htrans,
  output logic              hwrite,
  output logic [2:0]        hsize,
  output logic [2:0]        hburst,
  output logic [6:0]        hprot,
  output logic [DATA_W/8-1:0] hbstrb,
  output logic [DATA_W-1:0] hwdata,
  input  logic [DATA_W-1:0] hrdata,
  input  logic              hready,
  input  logic [1:0]        hresp
);

  ctlStrobe_t strobe;
  logic       reqFault;
  logic       lastBeat;

  dbgAhbControl uCtl (
    .clk      (clk),
    .rstN     (rstN),
    .reqValid (reqValid),
    .reqFault (reqFault),
    .lastBeat (lastBeat),
    .hready   (hready),
    .hresp    (hresp),
    .strobe   (strobe),
    .reqReady (reqReady),
    .rspValid (rspValid),
    .rspErr   (rspErr)
  );

  dbgAhbDatapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) uDp (
    .clk         (clk),
    .rstN        (rstN),
    .strobe      (strobe),
    .reqAddr     (reqAddr),
    .reqWrite    (reqWrite),
    .reqSize     (reqSize),
    .reqWdata    (reqWdata),
    .reqProt     (reqProt),
    .reqNonSec   (reqNonSec),
    .reqPacked   (reqPacked),
    .dbgEnable   (dbgEnable),
    .secureAllow (secureAllow),
    .hrdata      (hrdata),
    .reqFault    (reqFault),
    .lastBeat    (lastBeat),
    .haddr       (haddr),
    .hwrite      (hwrite),
    .hsize       (hsize),
    .hprot       (hprot),
    .hbstrb      (hbstrb),
    .hwdata      (hwdata),
    .rspData     (rspData)
  );

  assign htrans = strobe.addrPhase ? HTRANS_NONSEQ : HTRANS_IDLE;
  assign hburst = HBURST_SINGLE;

endmodule

// File: rtl/dbgAhbSingleMasterChk.sv
module dbgAhbSingleMasterChk #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic              reqValid,
  input logic              reqReady,
  input logic              dbgEnable,
  input logic              rspValid,
  input logic              rspErr,
  input logic [ADDR_W-1:0] haddr,
  input logic [1:0]        htrans,
  input logic [2:0]        hsize,
  input logic [6:0]        hprot,
  input logic              hready
);

  a_r1_single_pulse: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |=> !rspValid);

  a_r2_disabled_no_bus: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady && !dbgEnable) |=> (htrans == 2'b00 && rspValid && rspErr));

  a_r4_prot_held: assert property (@(posedge clk) disable iff (!rstN)
    (htrans == 2'b10 && !hready) |=> $stable(hprot));

  a_r6_aligned_bus: assert property (@(posedge clk) disable iff (!rstN)
    (htrans == 2'b10) |-> (hsize <= 3'd2 && (hsize != 3'd1 || !haddr[0])
                           && (hsize != 3'd2 || haddr[1:0] == 2'b00)));

  a_r7_idle_after_addr: assert property (@(posedge clk) disable iff (!rstN)
    (htrans == 2'b10 && hready) |=> htrans == 2'b00);

  a_r8_addr_hold: assert property (@(posedge clk) disable iff (!rstN)
    (htrans == 2'b10 && !hready) |=> (htrans == 2'b10 && $stable(haddr)));

  a_r12_idle_when_ready: assert property (@(posedge clk) disable iff (!rstN)
    reqReady |-> htrans == 2'b00);

endmodule

bind dbgAhbSingleMaster dbgAhbSingleMasterChk #(.ADDR_W(ADDR_W)) uChk (
  .clk       (clk),
  .rstN      (rstN),
  .reqValid  (reqValid),
  .reqReady  (reqReady),
  .dbgEnable (dbgEnable),
  .rspValid  (rspValid),
  .rspErr    (rspErr),
  .haddr     (haddr),
  .htrans    (htrans),
  .hsize     (hsize),
  .hprot     (hprot),
  .hready    (hready)
);

// File: tb/dbgAhbSingleMaster_test.sv
module dbgAhbSingleMaster_test;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic        reqReady;
  logic [31:0] reqAddr = '0;
  logic        reqWrite = 1'b0;
  logic [2:0]  reqSize = '0;
  logic [31:0] reqWdata = '0;
  logic [4:0]  reqProt = '0;
  logic        reqNonSec = 1'b1;
  logic        reqPacked = 1'b0;
  logic        rspValid;
  logic        rspErr;
  logic [31:0] rspData;
  logic        dbgEnable = 1'b1;
  logic        secureAllow = 1'b0;
  logic [31:0] haddr;
  logic [1:0]  htrans;
  logic        hwrite;
  logic [2:0]  hsize;
  logic [2:0]  hburst;
  logic [6:0]  hprot;
  logic [3:0]  hbstrb;
  logic [31:0] hwdata;
  logic [31:0] hrdata;
  logic        hready;
  logic [1:0]  hresp;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  dbgAhbSingleMaster uut (.*);

  // Slave model: byte at address n holds n; error at >= 0x40 and at 0x3D
  logic [31:0] mem [16];
  logic        dPend = 1'b0;
  logic [7:0]  dAddr = '0;
  logic        dWrite = 1'b0;
  logic        dErr = 1'b0;
  logic [3:0]  dStrb = '0;
  int          waitCnt = 0;
  int          waitCfg = 0;
  logic        holdLow = 1'b0;
  logic [1:0]  respCode = 2'b01;
  int          busCount = 0;
  int          nonseqCycles = 0;
  logic [6:0]  lastHprot = '0;
  logic [3:0]  lastStrb = '0;
  logic [2:0]  lastBurst = '0;
  logic [31:0] lastAddr = '0;

  assign hready = (dPend ? (waitCnt == 0) : 1'b1) && !holdLow;
  assign hresp  = (dPend && dErr && waitCnt == 0) ? respCode : 2'b00;
  assign hrdata = (dPend && dAddr < 8'h40) ? mem[dAddr[5:2]] : 32'h0;

  always @(posedge clk) begin
    if (dPend && hready) begin
      if (dWrite && !dErr) begin
        for (int i = 0; i < 4; i++) begin
          if (dStrb[i]) mem[dAddr[5:2]][8*i +: 8] <= hwdata[8*i +: 8];
        end
      end
      dPend <= 1'b0;
    end else if (dPend && waitCnt != 0) begin
      waitCnt <= waitCnt - 1;
    end
    if (htrans == 2'b10) nonseqCycles <= nonseqCycles + 1;
    if (htrans == 2'b10 && hready) begin
      dPend     <= 1'b1;
      dAddr     <= haddr[7:0];
      dWrite    <= hwrite;
      dStrb     <= hbstrb;
      dErr      <= (haddr >= 32'h40) || (haddr == 32'h3D);
      waitCnt   <= waitCfg;
      busCount  <= busCount + 1;
      lastHprot <= hprot;
      lastStrb  <= hbstrb;
      lastBurst <= hburst;
      lastAddr  <= haddr;
    end
  end

  int cycles = 0;
  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 150000) begin
      errors = errors + 1;
      $display("FAIL watchdog expired actual %0d expected below 150000", cycles);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic check(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic sendReq(input logic [31:0] a, input logic wr, input logic [2:0] sz,
                         input logic [31:0] wd, input logic [4:0] pr, input logic ns,
                         input logic pk, input logic en, input logic sa);
    @(negedge clk);
    while (!reqReady) @(negedge clk);
    reqAddr = a; reqWrite = wr; reqSize = sz; reqWdata = wd; reqProt = pr;
    reqNonSec = ns; reqPacked = pk; dbgEnable = en; secureAllow = sa;
    reqValid = 1'b1;
    @(negedge clk);
    reqValid = 1'b0;
  endtask

  task automatic waitRsp(output logic [31:0] d, output logic e);
    while (!rspValid) @(negedge clk);
    d = rspData;
    e = rspErr;
  endtask

  typedef struct packed {
    logic [7:0]  addr;
    logic        wr;
    logic [2:0]  sz;
    logic        pk;
    logic        ns;
    logic        en;
    logic        sa;
    logic [31:0] wd;
    logic [31:0] ed;
    logic        ee;
    logic [2:0]  eb;
  } vec_t;

  localparam int NV = 20;
  localparam vec_t VECS [NV] = '{
    '{8'h04, 1'b0, 3'd2, 1'b0, 1'b1, 1'b1, 1'b0, 32'h0, 32'h07060504, 1'b0, 3'd1}, // R7 word
    '{8'h0B, 1'b0, 3'd0, 1'b0, 1'b1, 1'b1, 1'b0, 32'h0, 32'h0B000000, 1'b0, 3'd1}, // R5 byte lane 3
    '{8'h0E, 1'b0, 3'd1, 1'b0, 1'b1, 1'b1, 1'b0, 32'h0, 32'h0F0E0000, 1'b0, 3'd1}, // R5 half
    '{8'h10, 1'b0, 3'd0, 1'b1, 1'b1, 1'b1, 1'b0, 32'h0, 32'h13121110, 1'b0, 3'd4}, // R10
    '{8'h14, 1'b0, 3'd1, 1'b1, 1'b1, 1'b1, 1'b0, 32'h0, 32'h17161514, 1'b0, 3'd2}, // R10
    '{8'h1A, 1'b0, 3'd0, 1'b1, 1'b1, 1'b1, 1'b0, 32'h0, 32'h1B1A0000, 1'b0, 3'd2}, // R10 offset
    '{8'h20, 1'b1, 3'd2, 1'b0, 1'b1, 1'b1, 1'b0, 32'hDEADBEEF, 32'h0, 1'b0, 3'd1},
    '{8'h20, 1'b0, 3'd2, 1'b0, 1'b1, 1'b1, 1'b0, 32'h0, 32'hDEADBEEF, 1'b0, 3'd1},
    '{8'h25, 1'b1, 3'd0, 1'b0, 1'b1, 1'b1, 1'b0, 32'hAABBCCDD, 32'h0, 1'b0, 3'd1}, // R5 write lane
    '{8'h24, 1'b0, 3'd2, 1'b0, 1'b1, 1'b1, 1'b0, 32'h0, 32'h2726CC24, 1'b0, 3'd1},
    '{8'h28, 1'b1, 3'd1, 1'b1, 1'b1, 1'b1, 1'b0, 32'h55667788, 32'h0, 1'b0, 3'd2}, // R10 write
    '{8'h28, 1'b0, 3'd2, 1'b0, 1'b1, 1'b1, 1'b0, 32'h0, 32'h55667788, 1'b0, 3'd1},
    '{8'h31, 1'b0, 3'd1, 1'b0, 1'b1, 1'b1, 1'b0, 32'h0, 32'h0, 1'b1, 3'd0},        // R6 misaligned
    '{8'h30, 1'b0, 3'd3, 1'b0, 1'b1, 1'b1, 1'b0, 32'h0, 32'h0, 1'b1, 3'd0},        // R6 size
    '{8'h30, 1'b0, 3'd2, 1'b0, 1'b1, 1'b0, 1'b0, 32'h0, 32'h0, 1'b1, 3'd0},        // R2
    '{8'h30, 1'b0, 3'd2, 1'b0, 1'b0, 1'b1, 1'b0, 32'h0, 32'h0, 1'b1, 3'd0},        // R3 blocked
    '{8'h30, 1'b0, 3'd2, 1'b0, 1'b0, 1'b1, 1'b1, 32'h0, 32'h33323130, 1'b0, 3'd1}, // R3 allowed
    '{8'h80, 1'b0, 3'd2, 1'b0, 1'b1, 1'b1, 1'b0, 32'h0, 32'h0, 1'b1, 3'd1},        // R9
    '{8'h3C, 1'b0, 3'd0, 1'b1, 1'b1, 1'b1, 1'b0, 32'h0, 32'h0, 1'b1, 3'd2},        // R11 abort
    '{8'h0C, 1'b0, 3'd2, 1'b1, 1'b1, 1'b1, 1'b0, 32'h0, 32'h0F0E0D0C, 1'b0, 3'd1}  // R10 packed word
  };

  initial begin
    logic [31:0] d;
    logic        e;
    int          b0;
    int          n0;
    for (int i = 0; i < 16; i++) mem[i] = 32'h03020100 + 32'(i) * 32'h04040404;

    // R12 reset state
    repeat (3) @(negedge clk);
    check(htrans == 2'b00, "R12 htrans in reset", 32'(htrans), 32'h0);
    check(reqReady == 1'b1, "R12 reqReady in reset", 32'(reqReady), 32'h1);
    check(rspValid == 1'b0, "R12 rspValid in reset", 32'(rspValid), 32'h0);
    rstN = 1'b1;
    @(negedge clk);
    check(htrans == 2'b00 && reqReady && !rspValid, "R12 after reset",
          {30'h0, htrans}, 32'h0);

    // Table walk, without and with wait states
    for (int pass = 0; pass < 2; pass++) begin
      waitCfg = pass * 2;
      for (int v = 0; v < NV; v++) begin
        b0 = busCount;
        sendReq({24'h0, VECS[v].addr}, VECS[v].wr, VECS[v].sz, VECS[v].wd, 5'b00011,
                VECS[v].ns, VECS[v].pk, VECS[v].en, VECS[v].sa);
        waitRsp(d, e);
        check(e == VECS[v].ee, $sformatf("R9/R6/R2/R3 err vec %0d", v), 32'(e), 32'(VECS[v].ee));
        check(busCount - b0 == int'(VECS[v].eb), $sformatf("R10/R11 beats vec %0d", v),
              32'(busCount - b0), 32'(VECS[v].eb));
        if (!VECS[v].wr && !VECS[v].ee)
          check(d == VECS[v].ed, $sformatf("R10 data vec %0d", v), d, VECS[v].ed);
        check(lastBurst == 3'b000, "R7 hburst SINGLE", 32'(lastBurst), 32'h0);
      end
    end
    waitCfg = 0;

    // R1 pulse width and ignored request while busy
    waitCfg = 3;
    b0 = busCount;
    sendReq(32'h04, 1'b0, 3'd2, 32'h0, 5'b0, 1'b1, 1'b0, 1'b1, 1'b0);
    reqAddr = 32'h08; reqValid = 1'b1;
    @(negedge clk);
    reqValid = 1'b0;
    waitRsp(d, e);
    check(d == 32'h07060504 && !e, "R1 busy request ignored data", d, 32'h07060504);
    @(negedge clk);
    check(!rspValid, "R1 one-cycle pulse", 32'(rspValid), 32'h0);
    n0 = 0;
    repeat (6) begin
      @(negedge clk);
      if (rspValid) n0++;
    end
    check(n0 == 0, "R1 no second response", 32'(n0), 32'h0);
    check(busCount - b0 == 1, "R1 one bus transfer", 32'(busCount - b0), 32'h1);
    waitCfg = 0;

    // R4 protection mapping
    sendReq(32'h00, 1'b0, 3'd2, 32'h0, 5'b11111, 1'b1, 1'b0, 1'b1, 1'b0);
    waitRsp(d, e);
    check(lastHprot == 7'b1011011, "R4 hprot non-secure all ones", 32'(lastHprot), 32'h5B);
    sendReq(32'h00, 1'b0, 3'd2, 32'h0, 5'b00100, 1'b0, 1'b0, 1'b1, 1'b1);
    waitRsp(d, e);
    check(lastHprot == 7'b0000000, "R4 R3 hprot secure bit2 forced", 32'(lastHprot), 32'h0);

    // R5 strobes
    sendReq(32'h0B, 1'b0, 3'd0, 32'h0, 5'b0, 1'b1, 1'b0, 1'b1, 1'b0);
    waitRsp(d, e);
    check(lastStrb == 4'b1000, "R5 byte offset 3", 32'(lastStrb), 32'h8);
    sendReq(32'h0E, 1'b0, 3'd1, 32'h0, 5'b0, 1'b1, 1'b0, 1'b1, 1'b0);
    waitRsp(d, e);
    check(lastStrb == 4'b1100, "R5 half offset 2", 32'(lastStrb), 32'hC);

    // R7 one NONSEQ cycle per beat; R10 last address
    n0 = nonseqCycles;
    sendReq(32'h10, 1'b0, 3'd0, 32'h0, 5'b0, 1'b1, 1'b1, 1'b1, 1'b0);
    waitRsp(d, e);
    check(nonseqCycles - n0 == 4, "R7 NONSEQ cycles", 32'(nonseqCycles - n0), 32'h4);
    check(lastAddr == 32'h13, "R10 incrementing address", lastAddr, 32'h13);

    // R9 other error codes
    respCode = 2'b10;
    sendReq(32'h80, 1'b0, 3'd2, 32'h0, 5'b0, 1'b1, 1'b0, 1'b1, 1'b0);
    waitRsp(d, e);
    check(e == 1'b1, "R9 hresp 2'b10 is error", 32'(e), 32'h1);
    respCode = 2'b11;
    sendReq(32'h80, 1'b0, 3'd2, 32'h0, 5'b0, 1'b1, 1'b0, 1'b1, 1'b0);
    waitRsp(d, e);
    check(e == 1'b1, "R9 hresp 2'b11 is error", 32'(e), 32'h1);
    respCode = 2'b01;

    // R8 address phase held while hready low
    holdLow = 1'b1;
    b0 = busCount;
    sendReq(32'h18, 1'b0, 3'd2, 32'h0, 5'b0, 1'b1, 1'b0, 1'b1, 1'b0);
    repeat (3) begin
      @(negedge clk);
      check(htrans == 2'b10 && haddr == 32'h18, "R8 address held",
            haddr, 32'h18);
    end
    check(busCount == b0 && !rspValid, "R8 no completion while stalled",
          32'(busCount - b0), 32'h0);
    holdLow = 1'b0;
    waitRsp(d, e);
    check(d == 32'h1B1A1918 && !e, "R8 data after stall", d, 32'h1B1A1918);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule